// File: doc/BRIEF.md
# TDM Multichannel Serial Output Framer

This block puts up to six 16-bit channel words onto a single serial data line as a time-division frame. A sample strobe from the clock generator starts each sample period. On the next serial clock tick the block raises a one-period frame sync. After that it sends one fixed 16-bit slot per channel, in channel order, most significant bit first. The serial clock enable paces every change on the outputs. The block runs on the fast system clock and treats the enable as a single-cycle tick.

A per-channel enable mask picks which slots carry data. A disabled channel still keeps its place in the frame, but during its slot the line is released: the output-enable is low and the data pin is driven low internally. A mode input selects between two frame types. In data mode the captured channel samples are sent. In program mode only a control/status word is sent, in the first slot, and no converter data appears on the line.

Channel words are staged on the sample strobe. Words, mask and mode are then frozen into the outgoing frame when the frame sync begins. New samples that arrive mid-frame therefore go to the next frame.

Top module: `tdm_framer`

## Requirements
- R1: While reset is held and after its release, `fsync`, `sdoOe` and `sdo` are all 0, and no frame starts until a sample strobe has been seen.
- R2: After a sample strobe, the next `sclkEn` tick raises `fsync` for exactly one serial clock period, and `sdoOe` is 0 during that period. The first data bit follows on the next tick.
- R3: In data mode (`dataMode`=1) slot k carries channel k, where channel k is `chanWords[16k+15:16k]`. Slots go in order k=0..5, each 16 ticks long, MSB first. Outputs change only on an `sclkEn` tick.
- R4: A slot whose channel has `chanEnable[k]`=0 keeps its 16-tick place, with `sdoOe`=0 and `sdo`=0 throughout. An enabled slot has `sdoOe`=1.
- R5: In program mode (`dataMode`=0) the first slot carries `ctrlWord` MSB first with `sdoOe`=1. The other five slots have `sdoOe`=0, and no channel word is sent.
- R6: Channel words, mask and mode that change, or are re-strobed, after a frame's sync has begun do not alter that frame. They appear in the next frame.
- R7: After the last slot, `sdoOe` and `fsync` stay 0 on every tick until a new sample strobe starts the next frame.
- R8: A sample strobe that arrives during a frame makes the next frame start on the tick right after the last bit: `fsync` follows directly, with no idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleStrobe | input | 1 | One-cycle pulse at the start of each sample period |
| sclkEn | input | 1 | One-cycle serial clock tick |
| dataMode | input | 1 | 1 = data mode, 0 = program mode |
| chanEnable | input | 6 | Per-channel power enable, bit k = channel k |
| ctrlWord | input | 16 | Control/status word sent in program mode |
| chanWords | input | 96 | Six channel words, channel k at bits 16k+15:16k |
| sdo | output | 1 | Serial data, low when not enabled |
| sdoOe | output | 1 | Output-enable for the serial data pad |
| fsync | output | 1 | Frame sync, one serial period before slot 0 |

## Verification
The checker watches, on every cycle, the rules that need no knowledge of the frame content. These are: the sync lasts one tick, the line is released during sync, a released line reads low, outputs move only on a tick, and a sync rise always comes from a tick. Slot order, bit order, the placement of each channel word, the masked and program-mode slot patterns, shadowing against mid-frame updates, and back-to-back frames depend on the values sent. Only the bench scenarios can show these, by comparing each received slot with words computed from the stimulus.

// File: rtl/tdm_framer_pkg.sv
package tdm_framer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_SLOT = 2'd2
  } frameState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadFrame;  // freeze staged data into the shift register
    logic dataFrame;  // frame type for the load: 1 = samples, 0 = control word
    logic shiftBit;   // advance one serial bit
  } dpCtl_t;

endpackage

// File: rtl/tdm_framer_ctrl.sv
module tdm_framer_ctrl
  import tdm_framer_pkg::*;
#(
  parameter int NCH = 6,
  parameter int W   = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleStrobe,
  input  logic           sclkEn,
  input  logic           dataMode,
  input  logic [NCH-1:0] chanEnable,
  output dpCtl_t         ctl,
  output logic           lineOe,
  output logic           syncOut
);

  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [BW-1:0] LAST_BIT  = BW'(W - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NCH - 1);

  frameState_t      state;
  logic [BW-1:0]    bitCnt;
  logic [SW-1:0]    slotCnt;
  logic             pending;
  logic [NCH-1:0]   maskLatched;
  logic             modeLatched;

  logic             lastBit;
  logic             frameDone;
  logic             enterSync;

  assign lastBit   = (state == ST_SLOT) && (bitCnt == LAST_BIT);
  assign frameDone = lastBit && (slotCnt == LAST_SLOT);
  assign enterSync = sclkEn && pending && ((state == ST_IDLE) || frameDone);

  // a strobe arriving on the load cycle wins and stays pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else begin
      pending <= sampleStrobe | (pending & ~enterSync);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLatched <= '0;
      modeLatched <= 1'b0;
    end else if (enterSync) begin
      maskLatched <= chanEnable;
      modeLatched <= dataMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (sclkEn) begin
      unique case (state)
        ST_IDLE: begin
          if (pending) state <= ST_SYNC;
        end
        ST_SYNC: begin
          state   <= ST_SLOT;
          bitCnt  <= '0;
          slotCnt <= '0;
        end
        ST_SLOT: begin
          if (lastBit) begin
            bitCnt <= '0;
            if (frameDone) begin
              slotCnt <= '0;
              state   <= pending ? ST_SYNC : ST_IDLE;
            end else begin
              slotCnt <= slotCnt + 1'b1;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadFrame = enterSync;
    ctl.dataFrame = dataMode;
    ctl.shiftBit  = sclkEn && (state == ST_SLOT);
  end

  always_comb begin
    lineOe = 1'b0;
    if (state == ST_SLOT) begin
      if (modeLatched) lineOe = maskLatched[slotCnt];
      else             lineOe = (slotCnt == '0);
    end
  end

  assign syncOut = (state == ST_SYNC);

endmodule

// File: rtl/tdm_framer_dp.sv
module tdm_framer_dp
  import tdm_framer_pkg::*;
#(
  parameter int NCH = 6,
  parameter int W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStrobe,
  input  logic [NCH*W-1:0] chanWords,
  input  logic [W-1:0]     ctrlWord,
  input  dpCtl_t           ctl,
  input  logic             lineOe,
  output logic             sdo
);

  localparam int FW = NCH * W;

  logic [W-1:0]  stageWord [NCH];
  logic [FW-1:0] frameImage;
  logic [FW-1:0] shiftReg;

  // staging registers, one per channel
  for (genvar i = 0; i < NCH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             stageWord[i] <= '0;
      else if (sampleStrobe) stageWord[i] <= chanWords[i*W +: W];
    end
  end

  // channel 0 sits at the top so it leaves first
  always_comb begin
    frameImage = '0;
    if (ctl.dataFrame) begin
      for (int i = 0; i < NCH; i++) begin
        frameImage[(NCH-1-i)*W +: W] = stageWord[i];
      end
    end else begin
      frameImage[FW-1 -: W] = ctrlWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (ctl.loadFrame) shiftReg <= frameImage;
    else if (ctl.shiftBit)  shiftReg <= {shiftReg[FW-2:0], 1'b0};
  end

  assign sdo = lineOe & shiftReg[FW-1];

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_framer_pkg::*;
#(
  parameter int NCH = 6,
  parameter int W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStrobe,
  input  logic             sclkEn,
  input  logic             dataMode,
  input  logic [NCH-1:0]   chanEnable,
  input  logic [W-1:0]     ctrlWord,
  input  logic [NCH*W-1:0] chanWords,
  output logic             sdo,
  output logic             sdoOe,
  output logic             fsync
);

  dpCtl_t ctl;
  logic   lineOe;

  tdm_framer_ctrl #(.NCH(NCH), .W(W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .sclkEn       (sclkEn),
    .dataMode     (dataMode),
    .chanEnable   (chanEnable),
    .ctl          (ctl),
    .lineOe       (lineOe),
    .syncOut      (fsync)
  );

  tdm_framer_dp #(.NCH(NCH), .W(W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .chanWords    (chanWords),
    .ctrlWord     (ctrlWord),
    .ctl          (ctl),
    .lineOe       (lineOe),
    .sdo          (sdo)
  );

  assign sdoOe = lineOe;

endmodule

// File: rtl/tdm_framer_chk.sv
module tdm_framer_chk (
  input logic clk,
  input logic rstN,
  input logic sclkEn,
  input logic sdo,
  input logic sdoOe,
  input logic fsync
);

  p_sync_single_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fsync && sclkEn) |=> !fsync);

  p_sync_line_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    fsync |-> !sdoOe);

  p_released_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdo);

  p_tick_paced_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sclkEn |=> ($stable(fsync) && $stable(sdoOe) && $stable(sdo)));

  p_sync_from_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsync) |-> $past(sclkEn));

endmodule

bind tdm_framer tdm_framer_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclkEn (sclkEn),
  .sdo    (sdo),
  .sdoOe  (sdoOe),
  .fsync  (fsync)
);

// File: tb/sim_tdm_framer.sv
module sim_tdm_framer;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int W   = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sampleStrobe = 1'b0;
  logic             sclkEn = 1'b0;
  logic             dataMode = 1'b0;
  logic [NCH-1:0]   chanEnable = '0;
  logic [W-1:0]     ctrlWord = '0;
  logic [NCH*W-1:0] chanWords = '0;
  logic             sdo, sdoOe, fsync;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [NCH*W-1:0] nextWords;
  logic [NCH-1:0]   nextMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_framer #(.NCH(NCH), .W(W)) u0 (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sclkEn(sclkEn),
    .dataMode(dataMode), .chanEnable(chanEnable), .ctrlWord(ctrlWord),
    .chanWords(chanWords), .sdo(sdo), .sdoOe(sdoOe), .fsync(fsync)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); sclkEn = 1'b1;
    @(negedge clk); sclkEn = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); sampleStrobe = 1'b1;
    @(negedge clk); sampleStrobe = 1'b0;
  endtask

  // runs one frame from the sync period; words/mask/mode are the expected content
  task automatic runFrame(input logic [NCH*W-1:0] words, input logic [NCH-1:0] mask,
                          input bit mode, input logic [W-1:0] ctrl,
                          input bit inSync, input bit doMid, input bit expectNext,
                          input string req);
    logic [W-1:0] gotWord;
    logic [W-1:0] expWord;
    bit oeOk;
    bit expOe;
    if (!inSync) tick();
    check(fsync === 1'b1 && sdoOe === 1'b0, "R2", "sync period", {fsync, sdoOe}, 2'b10);
    for (int s = 0; s < NCH; s++) begin
      expOe   = mode ? mask[s] : (s == 0);
      expWord = !expOe ? '0 : (mode ? words[s*W +: W] : ctrl);
      gotWord = '0;
      oeOk    = 1'b1;
      for (int b = 0; b < W; b++) begin
        tick();
        if (fsync !== 1'b0 || sdoOe !== expOe) oeOk = 1'b0;
        gotWord = {gotWord[W-2:0], sdo};
        if (doMid && s == 1 && b == 4) begin
          chanWords  = nextWords;
          chanEnable = nextMask;
          dataMode   = ~dataMode;
          strobe();
          dataMode   = ~dataMode;
        end
      end
      check(oeOk, req, $sformatf("slot %0d enable", s), 32'(sdoOe), 32'(expOe));
      check(gotWord === expWord, req, $sformatf("slot %0d word", s), 32'(gotWord), 32'(expWord));
    end
    tick();
    if (expectNext)
      check(fsync === 1'b1 && sdoOe === 1'b0, "R8", "back-to-back sync", {fsync, sdoOe}, 2'b10);
    else
      check(fsync === 1'b0 && sdoOe === 1'b0, "R7", "idle after frame", {fsync, sdoOe}, 2'b00);
  endtask

  task automatic testReset();
    check(fsync === 1'b0 && sdoOe === 1'b0 && sdo === 1'b0, "R1", "in reset",
          {fsync, sdoOe, sdo}, 3'b000);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    check(fsync === 1'b0 && sdoOe === 1'b0 && sdo === 1'b0, "R1", "no frame without strobe",
          {fsync, sdoOe, sdo}, 3'b000);
  endtask

  task automatic testDataAll();
    dataMode = 1'b1; chanEnable = 6'b111111;
    chanWords = {16'hF00D, 16'h1357, 16'h8001, 16'h55AA, 16'hC3C3, 16'h9E21};
    strobe();
    check(fsync === 1'b0, "R2", "no sync before tick", 32'(fsync), 32'd0);
    runFrame(chanWords, chanEnable, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic testSparse();
    dataMode = 1'b1; chanEnable = 6'b010101;
    chanWords = {16'hFFFF, 16'h0F0F, 16'hFFFF, 16'hA001, 16'hFFFF, 16'h7FFE};
    strobe();
    runFrame(chanWords, chanEnable, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0, "R4");
  endtask

  task automatic testProgram();
    dataMode = 1'b0; chanEnable = 6'b111111; ctrlWord = 16'hA5C3;
    chanWords = {6{16'hFFFF}};
    strobe();
    runFrame(chanWords, chanEnable, 1'b0, ctrlWord, 1'b0, 1'b0, 1'b0, "R5");
  endtask

  task automatic testShadow();
    logic [NCH*W-1:0] oldWords;
    logic [NCH-1:0]   oldMask;
    dataMode = 1'b1; chanEnable = 6'b111111;
    chanWords = {16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h090A, 16'h0B0C};
    oldWords = chanWords; oldMask = chanEnable;
    nextWords = {16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hBABE, 16'h1234, 16'h4321};
    nextMask  = 6'b101110;
    strobe();
    runFrame(oldWords, oldMask, 1'b1, 16'h0, 1'b0, 1'b1, 1'b1, "R6");
    runFrame(nextWords, nextMask, 1'b1, 16'h0, 1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic testIdle();
    bit quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (fsync !== 1'b0 || sdoOe !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R7", "line stays idle without strobe", {fsync, sdoOe}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testDataAll();
    testSparse();
    testProgram();
    testShadow();
    testIdle();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule